// File: doc/BRIEF.md
# Display Test Pattern Generator

This block replaces the video path with a synthetic image whenever a display needs checking without frame memory. A timing generator feeds it the active-area column and row of each pixel, a data-enable strobe, and a one-cycle frame-start pulse. The generator draws a solid fill, a horizontal or vertical intensity ramp, eight vertical colour bars, a colour that cycles by itself every 64 frames, or grey noise. When patterns are switched off, the live video pixel is passed through with the same one-cycle delay.

The pixel stream runs at the pixel clock and has no ready signal. `de` acts as the input valid and `pix_valid` as the output valid. A display timing path cannot stall, so there is no back-pressure: every pixel offered with `de` high is produced on the next cycle. The mode, colour and user colour are sampled only on the frame-start cycle, so one frame never mixes two patterns.

Pixels are packed as {R, G, B}, with R in bits 29:20, G in bits 19:10 and B in bits 9:0, each 10 bits wide.

Top module: `test_pattern_gen`

## Requirements
- R1: After reset, `pix_valid` and `pix_out` are 0 and the held mode is pass-through.
- R2: `pix_valid` equals `de` from one cycle earlier. `pix_out` is 0 in every cycle in which `pix_valid` is 0.
- R3: `pat_type`, `pat_color` and the user colour are captured only in a cycle with `sof` high. They govern pixels from the next cycle on. Changes at any other time have no effect. `sof` is never raised together with `de`. Mode codes: 0 fill, 1 horizontal ramp, 2 vertical ramp, 3 automatic, 4 noise, 5 pass-through; codes 6 and 7 also mean pass-through.
- R4: In fill mode, colour codes 0 to 6 give white, red, green, blue, cyan, magenta and yellow. Each component is either 0 or 1023.
- R5: Colour code 8 uses the low 10 bits of `usr_r`, `usr_g` and `usr_b` as the colour.
- R6: In fill mode, colour code 7 draws bars. The bar index is floor(x*8/act_w), and indices 0 to 7 give white, yellow, cyan, green, magenta, red, blue, black.
- R7: The horizontal ramp is q = floor(x*1024/act_w). Each component is floor(c*q/1024), where c is the component of the selected colour.
- R8: The vertical ramp uses the same formula with y and act_h.
- R9: Colour code 7 in either ramp mode counts as white. Codes 9 to 15 give black in fill and ramp modes.
- R10: Noise mode outputs grey, with all three components equal to bits 15:6 of a 16-bit LFSR. The LFSR is seeded with 0xACE1 on `sof` and steps on every `de` cycle after the pixel is drawn. The step is next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R11: Automatic mode shows colour code (n/64) mod 7, where n is the number of `sof` pulses since reset. The colour select is ignored in this mode.
- R12: In pass-through mode, `pix_out` equals `vid_in` from one cycle earlier.
- R13: If the ramp denominator is 0, then q is 0. If the coordinate is at or beyond the denominator, then q is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Frame-start pulse; captures the selections |
| de | input | 1 | Data enable; input pixel valid |
| px_x | input | 12 | Active-area column |
| px_y | input | 12 | Active-area row |
| act_w | input | 12 | Active width in pixels |
| act_h | input | 12 | Active height in lines |
| pat_type | input | 3 | Pattern mode code |
| pat_color | input | 4 | Colour code |
| usr_r | input | 16 | User red, low 10 bits used |
| usr_g | input | 16 | User green, low 10 bits used |
| usr_b | input | 16 | User blue, low 10 bits used |
| vid_in | input | 30 | Live video pixel {R,G,B} |
| pix_valid | output | 1 | Output pixel valid |
| pix_out | output | 30 | Output pixel {R,G,B} |

## Verification
The following properties are checked in every cycle:
- the held selections change only after a frame-start cycle;
- pass-through output equals the previous video input;
- noise output is grey;
- the LFSR never reaches the all-zero state;
- the automatic colour index stays within the seven solid colours.

Other behaviours can only be shown by the bench scenarios, which compare against values computed from the requirements. These are the exact ramp arithmetic, the bar boundaries, the noise sequence after a reseed, the colour step on the 64th frame with its wrap after seven steps, and the edge cases of zero or exceeded width.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int LFSR_W = 16;
  localparam int NUM_SOLID = 7;

  localparam logic [2:0] PT_FILL  = 3'd0;
  localparam logic [2:0] PT_HRAMP = 3'd1;
  localparam logic [2:0] PT_VRAMP = 3'd2;
  localparam logic [2:0] PT_AUTO  = 3'd3;
  localparam logic [2:0] PT_NOISE = 3'd4;
  localparam logic [2:0] PT_PASS  = 3'd5;

  localparam logic [3:0] CS_BARS = 4'd7;
  localparam logic [3:0] CS_USER = 4'd8;

  // {r,g,b} on/off mask for the seven solid colours
  function automatic logic [2:0] solid_mask(input logic [3:0] code);
    case (code)
      4'd0: solid_mask = 3'b111;
      4'd1: solid_mask = 3'b100;
      4'd2: solid_mask = 3'b010;
      4'd3: solid_mask = 3'b001;
      4'd4: solid_mask = 3'b011;
      4'd5: solid_mask = 3'b101;
      4'd6: solid_mask = 3'b110;
      default: solid_mask = 3'b000;
    endcase
  endfunction

  // {r,g,b} mask for each bar, left to right
  function automatic logic [2:0] bar_mask(input logic [2:0] idx);
    case (idx)
      3'd0: bar_mask = 3'b111;
      3'd1: bar_mask = 3'b110;
      3'd2: bar_mask = 3'b011;
      3'd3: bar_mask = 3'b010;
      3'd4: bar_mask = 3'b101;
      3'd5: bar_mask = 3'b100;
      3'd6: bar_mask = 3'b001;
      default: bar_mask = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int CRD_W = 12,
  parameter int CW    = 10
) (
  input  logic [CRD_W-1:0] num,
  input  logic [CRD_W-1:0] den,
  output logic [CW-1:0]    ramp
);
  localparam int QW = CRD_W + CW;
  logic [QW-1:0] scaled_num;
  logic [QW-1:0] wide_den;
  logic [QW-1:0] quo;

  always_comb begin
    scaled_num = {num, {CW{1'b0}}};
    wide_den   = {{CW{1'b0}}, den};
    quo        = '0;
    if (den == '0)
      ramp = '0;
    else if (num >= den)
      ramp = '1;
    else begin
      quo  = scaled_num / wide_den;
      ramp = quo[CW-1:0];
    end
  end
endmodule

// File: rtl/tpg_snow.sv
module tpg_snow import tpg_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (!rst_n || reseed)
      state <= SEED;
    else if (step)
      state <= {state[LFSR_W-2:0], fb};
  end

  // R10
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/tpg_auto.sv
module tpg_auto import tpg_pkg::*; #(
  parameter int FRAMES_PER_STEP = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  output logic [2:0] idx
);
  localparam int FW = (FRAMES_PER_STEP > 2) ? $clog2(FRAMES_PER_STEP) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAMES_PER_STEP - 1);
  logic [FW-1:0] frm_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt <= '0;
      idx     <= '0;
    end else if (frame_tick) begin
      if (frm_cnt == LAST) begin
        frm_cnt <= '0;
        idx     <= (idx == 3'(NUM_SOLID - 1)) ? 3'd0 : idx + 3'd1;
      end else begin
        frm_cnt <= frm_cnt + 1'b1;
      end
    end
  end

  // R11
  auto_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx < 3'(NUM_SOLID));
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen import tpg_pkg::*; #(
  parameter int CW = 10,
  parameter int CRD_W = 12,
  parameter int FRAMES_PER_STEP = 64,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              de,
  input  logic [CRD_W-1:0]  px_x,
  input  logic [CRD_W-1:0]  px_y,
  input  logic [CRD_W-1:0]  act_w,
  input  logic [CRD_W-1:0]  act_h,
  input  logic [2:0]        pat_type,
  input  logic [3:0]        pat_color,
  input  logic [15:0]       usr_r,
  input  logic [15:0]       usr_g,
  input  logic [15:0]       usr_b,
  input  logic [3*CW-1:0]   vid_in,
  output logic              pix_valid,
  output logic [3*CW-1:0]   pix_out
);
  localparam int PIX_W = 3 * CW;

  // selections held for the whole frame
  logic [2:0]       cur_type;
  logic [3:0]       cur_col;
  logic [PIX_W-1:0] cur_usr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_type <= PT_PASS;
      cur_col  <= '0;
      cur_usr  <= '0;
    end else if (sof) begin
      cur_type <= pat_type;
      cur_col  <= pat_color;
      cur_usr  <= {usr_r[CW-1:0], usr_g[CW-1:0], usr_b[CW-1:0]};
    end
  end

  // one divider shared by ramps and bar index
  logic             vert;
  logic [CRD_W-1:0] r_num, r_den;
  logic [CW-1:0]    ramp;
  assign vert  = (cur_type == PT_VRAMP);
  assign r_num = vert ? px_y : px_x;
  assign r_den = vert ? act_h : act_w;

  tpg_ramp #(.CRD_W(CRD_W), .CW(CW)) u_ramp (
    .num(r_num), .den(r_den), .ramp(ramp)
  );

  logic [LFSR_W-1:0] lfsr;
  tpg_snow #(.SEED(LFSR_SEED)) u_snow (
    .clk(clk), .rst_n(rst_n), .reseed(sof), .step(de), .state(lfsr)
  );

  logic [2:0] auto_idx;
  tpg_auto #(.FRAMES_PER_STEP(FRAMES_PER_STEP)) u_auto (
    .clk(clk), .rst_n(rst_n), .frame_tick(sof), .idx(auto_idx)
  );

  function automatic logic [PIX_W-1:0] expand(input logic [2:0] m);
    expand = {{CW{m[2]}}, {CW{m[1]}}, {CW{m[0]}}};
  endfunction

  logic [3:0]       code;
  logic [PIX_W-1:0] base;
  logic [PIX_W-1:0] shaded;
  logic [PIX_W-1:0] nxt;
  logic [CW-1:0]    grey;

  assign code = (cur_type == PT_AUTO) ? {1'b0, auto_idx} : cur_col;
  assign grey = lfsr[LFSR_W-1 -: CW];

  always_comb begin
    if (code < CS_BARS)
      base = expand(solid_mask(code));
    else if (code == CS_BARS)
      base = (cur_type == PT_FILL) ? expand(bar_mask(ramp[CW-1 -: 3]))
                                   : expand(3'b111);
    else if (code == CS_USER)
      base = cur_usr;
    else
      base = '0;
  end

  for (genvar k = 0; k < 3; k++) begin : g_shade
    logic [2*CW-1:0] prod;
    assign prod = base[k*CW +: CW] * ramp;
    assign shaded[k*CW +: CW] = prod[2*CW-1:CW];
  end

  always_comb begin
    case (cur_type)
      PT_FILL, PT_AUTO:   nxt = base;
      PT_HRAMP, PT_VRAMP: nxt = shaded;
      PT_NOISE:           nxt = {grey, grey, grey};
      default:            nxt = vid_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      pix_valid <= de;
      pix_out   <= de ? nxt : '0;
    end
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(cur_type) && $stable(cur_col) && $stable(cur_usr));

  // R12
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de && (cur_type >= PT_PASS) |=> pix_out == $past(vid_in));

  // R10
  noise_grey_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de && (cur_type == PT_NOISE) |=>
      pix_out[CW-1:0] == pix_out[2*CW-1:CW] && pix_out[2*CW-1:CW] == pix_out[3*CW-1:2*CW]);
endmodule

// File: tb/test_pattern_gen_test.sv
module test_pattern_gen_test;
  logic clk = 1'b0;
  logic rst_n, sof, de;
  logic [11:0] px_x, px_y, act_w, act_h;
  logic [2:0] pat_type;
  logic [3:0] pat_color;
  logic [15:0] usr_r, usr_g, usr_b;
  logic [29:0] vid_in;
  logic pix_valid;
  logic [29:0] pix_out;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_type;
  logic [3:0] m_col;
  logic [29:0] m_usr;
  logic [15:0] m_lfsr;
  int m_nsof;

  always #5 clk = ~clk;

  test_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .de(de), .px_x(px_x), .px_y(px_y),
    .act_w(act_w), .act_h(act_h), .pat_type(pat_type), .pat_color(pat_color),
    .usr_r(usr_r), .usr_g(usr_g), .usr_b(usr_b), .vid_in(vid_in),
    .pix_valid(pix_valid), .pix_out(pix_out)
  );

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b pix=%h expected valid=%0b pix=%h",
               req, act[30], act[29:0], exp[30], exp[29:0]);
    end
  endtask

  function automatic logic [29:0] mask2pix(input logic [2:0] m);
    return {{10{m[2]}}, {10{m[1]}}, {10{m[0]}}};
  endfunction

  function automatic logic [2:0] solid(input int c);
    logic [2:0] t[7] = '{3'b111, 3'b100, 3'b010, 3'b001, 3'b011, 3'b101, 3'b110};
    return t[c];
  endfunction

  function automatic logic [2:0] bar(input int b);
    logic [2:0] t[8] = '{3'b111, 3'b110, 3'b011, 3'b010, 3'b101, 3'b100, 3'b001, 3'b000};
    return t[b];
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [29:0] exp_px(input int x, y, w, h, input logic [29:0] vid);
    int t, code, num, den, q;
    logic [29:0] b;
    logic [29:0] r;
    t = (m_type > 3'd5) ? 5 : int'(m_type);
    if (t == 5) return vid;
    if (t == 4) return {m_lfsr[15:6], m_lfsr[15:6], m_lfsr[15:6]};
    code = (t == 3) ? (m_nsof / 64) % 7 : int'(m_col);
    num = (t == 2) ? y : x;
    den = (t == 2) ? h : w;
    if (den == 0) q = 0;
    else if (num >= den) q = 1023;
    else q = (num * 1024) / den;
    if (code < 7) b = mask2pix(solid(code));
    else if (code == 7) b = (t == 0) ? mask2pix(bar(q / 128)) : mask2pix(3'b111);
    else if (code == 8) b = m_usr;
    else b = '0;
    if (t == 1 || t == 2) begin
      r[29:20] = 10'((int'(b[29:20]) * q) / 1024);
      r[19:10] = 10'((int'(b[19:10]) * q) / 1024);
      r[9:0]   = 10'((int'(b[9:0]) * q) / 1024);
      return r;
    end
    return b;
  endfunction

  task automatic frame(input int t, input int c, input logic [15:0] ur, ug, ub);
    sof = 1'b1; de = 1'b0;
    pat_type = 3'(t); pat_color = 4'(c);
    usr_r = ur; usr_g = ug; usr_b = ub;
    @(negedge clk);
    sof = 1'b0;
    m_type = 3'(t); m_col = 4'(c);
    m_usr = {ur[9:0], ug[9:0], ub[9:0]};
    m_lfsr = 16'hACE1;
    m_nsof++;
  endtask

  task automatic pixel(input string req, input int x, y, w, h, input logic [29:0] vid);
    logic [29:0] e;
    de = 1'b1; px_x = 12'(x); px_y = 12'(y); act_w = 12'(w); act_h = 12'(h); vid_in = vid;
    e = exp_px(x, y, w, h, vid);
    @(negedge clk);
    check(req, {pix_valid, pix_out}, {1'b1, e});
    m_lfsr = lfsr_next(m_lfsr);
    de = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sof = 1'b0; de = 1'b0; px_x = '0; px_y = '0; act_w = 12'd64; act_h = 12'd32;
    pat_type = 3'd0; pat_color = 4'd0; usr_r = '0; usr_g = '0; usr_b = '0; vid_in = '0;
    m_type = 3'd5; m_col = '0; m_usr = '0; m_lfsr = 16'hACE1; m_nsof = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {pix_valid, pix_out}, 31'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R12: pass-through before any frame start
    pixel("R1", 3, 4, 64, 32, 30'h1234_5678);
    // R2: idle cycle gives zero
    vid_in = 30'h3FFF_FFFF;
    @(negedge clk);
    check("R2", {pix_valid, pix_out}, 31'd0);

    // R4 solid fills
    for (int c = 0; c < 7; c++) begin
      frame(0, c, 0, 0, 0);
      pixel("R4", c * 5, 1, 100, 50, '0);
    end
    // R5 user colour, high bits ignored
    frame(0, 8, 16'hFC01, 16'h0155, 16'h83FF);
    pixel("R5", 7, 7, 100, 50, '0);
    // R6 bar boundaries, width 80 -> 10 px per bar
    frame(0, 7, 0, 0, 0);
    for (int b = 0; b < 8; b++) begin
      pixel("R6", b * 10, 0, 80, 20, '0);
      pixel("R6", b * 10 + 9, 0, 80, 20, '0);
    end
    // R7 horizontal ramp
    frame(1, 0, 0, 0, 0);
    pixel("R7", 0, 0, 1920, 1080, '0);
    pixel("R7", 1919, 0, 1920, 1080, '0);
    pixel("R7", 960, 5, 1920, 1080, '0);
    frame(1, 8, 16'd700, 16'd300, 16'd1023);
    pixel("R7", 333, 0, 1000, 10, '0);
    // R8 vertical ramp
    frame(2, 4, 0, 0, 0);
    pixel("R8", 5, 0, 640, 480, '0);
    pixel("R8", 5, 479, 640, 480, '0);
    pixel("R8", 5, 120, 640, 480, '0);
    // R9 bars code in ramp mode -> white, code 12 -> black
    frame(1, 7, 0, 0, 0);
    pixel("R9", 500, 0, 1000, 10, '0);
    frame(0, 12, 0, 0, 0);
    pixel("R9", 1, 1, 10, 10, '0);
    // R13 zero width and beyond width
    frame(1, 0, 0, 0, 0);
    pixel("R13", 5, 0, 0, 10, '0);
    pixel("R13", 50, 0, 40, 10, '0);
    // R3 selection change without frame start is ignored
    pat_type = 3'd5; pat_color = 4'd3;
    pixel("R3", 20, 0, 40, 10, 30'h2AA_AAAA);
    // R10 noise sequence after reseed
    frame(4, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) pixel("R10", i, 0, 64, 8, '0);
    frame(4, 0, 0, 0, 0);
    pixel("R10", 0, 0, 64, 8, '0);
    // R12 explicit pass-through, including code 7
    frame(7, 0, 0, 0, 0);
    pixel("R12", 1, 1, 8, 8, 30'h0F0_F0F0);
    frame(5, 0, 0, 0, 0);
    pixel("R12", 1, 1, 8, 8, 30'h155_5555);

    // R11 automatic cycling: step at the 64th frame start, wrap after seven steps
    while ((m_nsof % 64) != 63) frame(3, 2, 0, 0, 0);
    pixel("R11", 0, 0, 8, 8, '0);
    frame(3, 2, 0, 0, 0);
    pixel("R11", 0, 0, 8, 8, '0);
    while (m_nsof < 448) frame(3, 5, 0, 0, 0);
    pixel("R11", 0, 0, 8, 8, '0);

    // random mix of modes and colours
    for (int f = 0; f < 30; f++) begin
      int t, w, h;
      t = int'($urandom_range(0, 7));
      if (t == 3) t = 0;
      frame(t, int'($urandom_range(0, 15)), 16'($urandom), 16'($urandom), 16'($urandom));
      w = int'($urandom_range(1, 4095));
      h = int'($urandom_range(1, 4095));
      for (int p = 0; p < 15; p++)
        pixel("R7", int'($urandom_range(0, w - 1)), int'($urandom_range(0, h - 1)), w, h,
              30'($urandom));
    end

    @(negedge clk);
    check("R2", {pix_valid, pix_out}, 31'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule